// File: doc/BRIEF.md
# Rotate-and-Mask Unit

This unit performs the datapath half of rotate-then-mask integer operations. A 64-bit source is rotated left by a programmable amount. A contiguous mask is built from a start index and a stop index, and the two are ANDed together. In word mode, the low 32 bits of the source are first copied into both halves of a 64-bit word, so that a 64-bit rotate behaves like a 32-bit rotate in each half. A separate option sign-extends the low word of the source to 64 bits before the rotate.

One request is accepted on any cycle when `req_valid` is high. The rotated value, the mask and the masked result come out together one clock later, marked by `rsp_valid`. The unit has no back-pressure.

Top module: `rotmask_unit`

## Requirements
- R1: Mask indices count from the most significant end: index k is bit 63-k. When start <= stop, the mask has ones at indices start..stop inclusive and zeros elsewhere. Examples: start 37, stop 63 gives 0x0000000007ffffff; start 0, stop 37 gives 0xfffffffffc000000.
- R2: When start == stop, the mask is a single one at that index. Index 32 gives 0x0000000080000000.
- R3: When start > stop, the mask wraps. It has ones at indices start..63 and 0..stop, and zeros between. Example: start 47, stop 37 gives 0xfffffffffc01ffff.
- R4: In 64-bit mode (`word_mode`=0), the rotated value is the source rotated left by `rot_amt` (6 bits). Example: 0xdeadbeef12345678 rotated by 10 gives 0xb6fbbc48d159e37a.
- R5: In word mode (`word_mode`=1), the source's low 32 bits are placed in both halves, then rotated left by `rot_amt[4:0]`. Bit 5 of `rot_amt` is ignored. Example: 0xdeadbeef rotated by 10 gives 0xb6fbbf7a in each half.
- R6: When `sext_en`=1, bit 31 of the source is copied into bits 63:32 before the rotate. Example: 0x80000000 becomes 0xffffffff80000000.
- R7: `rsp_result` equals `rsp_rotated` AND `rsp_mask`. With an all-ones source and rotate amount 0, the result equals the mask.
- R8: `rsp_valid` is high exactly one clock after a cycle in which `req_valid` was high. All three data outputs change only on such clocks.
- R9: A synchronous active-high reset clears `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request strobe |
| src | input | 64 | source operand |
| rot_amt | input | 6 | rotate-left amount |
| mask_start | input | 6 | first mask index (MSB-0) |
| mask_stop | input | 6 | last mask index (MSB-0) |
| word_mode | input | 1 | 1 = replicated 32-bit rotate |
| sext_en | input | 1 | sign-extend low word before rotate |
| rsp_valid | output | 1 | response strobe |
| rsp_rotated | output | 64 | rotated operand |
| rsp_mask | output | 64 | generated mask |
| rsp_result | output | 64 | rotated AND mask |

## Verification
The hardest case to reach from the ports is the boundary between the wrapping and non-wrapping mask shapes. These are start == stop at either extreme, start 0 with stop 63, and start 63 with stop 0. Random indices rarely land on them, so they are driven directly. The ignored bit 5 of the word-mode rotate amount is also hard to reach by chance. Random word-mode requests are therefore sent twice, once with each value of that bit, and both responses must match the same expected value.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
    localparam int XLEN = 64;
    localparam int HLEN = XLEN / 2;
    localparam int IDXW = $clog2(XLEN);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [IDXW-1:0] idx_t;

    typedef struct packed {
        word_t rotated;
        word_t mask;
        word_t result;
    } rm_out_t;

    // all ones from MSB-0 index k down to the LSB
    function automatic word_t ones_from(input idx_t k);
        word_t full;
        full = '1;
        return full >> k;
    endfunction
endpackage

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen
    import rotmask_pkg::*;
(
    input  idx_t  start_idx,
    input  idx_t  stop_idx,
    output word_t mask
);
    word_t from_start;
    word_t past_stop;

    always_comb begin
        from_start = ones_from(start_idx);
        // ones strictly after stop: ones_from(stop) shifted right by one
        past_stop  = ones_from(stop_idx) >> 1;
        if (start_idx <= stop_idx)
            mask = from_start & ~past_stop;
        else
            mask = from_start | ~past_stop;
    end
endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator
    import rotmask_pkg::*;
(
    input  word_t src,
    input  idx_t  amt,
    input  logic  word_mode,
    input  logic  sext_en,
    output word_t rotated
);
    word_t pre;
    word_t doubled;
    idx_t  eff_amt;

    always_comb begin
        pre = src;
        if (sext_en)
            pre[XLEN-1:HLEN] = {HLEN{src[HLEN-1]}};
        if (word_mode) begin
            pre     = {pre[HLEN-1:0], pre[HLEN-1:0]};
            eff_amt = {1'b0, amt[IDXW-2:0]};
        end else begin
            eff_amt = amt;
        end
        doubled = '0;
        {doubled, rotated} = {pre, pre} << eff_amt;
        rotated = doubled;
    end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rotmask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [63:0] src,
    input  logic [5:0]  rot_amt,
    input  logic [5:0]  mask_start,
    input  logic [5:0]  mask_stop,
    input  logic        word_mode,
    input  logic        sext_en,
    output logic        rsp_valid,
    output logic [63:0] rsp_rotated,
    output logic [63:0] rsp_mask,
    output logic [63:0] rsp_result
);
    word_t   rot_c;
    word_t   mask_c;
    rm_out_t nxt;
    rm_out_t held;
    logic    vld_q;

    rotmask_rotator u_rot (
        .src       (src),
        .amt       (rot_amt),
        .word_mode (word_mode),
        .sext_en   (sext_en),
        .rotated   (rot_c)
    );

    rotmask_maskgen u_mask (
        .start_idx (mask_start),
        .stop_idx  (mask_stop),
        .mask      (mask_c)
    );

    always_comb begin
        nxt.rotated = rot_c;
        nxt.mask    = mask_c;
        nxt.result  = rot_c & mask_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            held  <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid)
                held <= nxt;
        end
    end

    assign rsp_valid   = vld_q;
    assign rsp_rotated = held.rotated;
    assign rsp_mask    = held.mask;
    assign rsp_result  = held.result;
endmodule

// File: rtl/rotmask_checker.sv
module rotmask_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] src,
    input logic [5:0]  rot_amt,
    input logic [5:0]  mask_start,
    input logic [5:0]  mask_stop,
    input logic        rsp_valid,
    input logic [63:0] rsp_rotated,
    input logic [63:0] rsp_mask,
    input logic [63:0] rsp_result
);
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_result) && $stable(rsp_mask) && $stable(rsp_rotated));
    a_r7_and: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_result == (rsp_rotated & rsp_mask));
    a_r2_single: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mask_start == mask_stop) |=> $countones(rsp_mask) == 1);
    a_r7_allones: assert property (@(posedge clk) disable iff (rst)
        (req_valid && src == '1 && rot_amt == 0) |=> rsp_result == rsp_mask);
    a_r9_reset: assert property (@(posedge clk)
        rst |=> !rsp_valid);
endmodule

bind rotmask_unit rotmask_checker i_rotmask_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .src(src), .rot_amt(rot_amt),
    .mask_start(mask_start), .mask_stop(mask_stop), .rsp_valid(rsp_valid),
    .rsp_rotated(rsp_rotated), .rsp_mask(rsp_mask), .rsp_result(rsp_result)
);

// File: tb/test_rotmask_unit.sv
module test_rotmask_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] src;
    logic [5:0]  rot_amt, mask_start, mask_stop;
    logic        word_mode, sext_en;
    logic        rsp_valid;
    logic [63:0] rsp_rotated, rsp_mask, rsp_result;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rotmask_unit i_rotmask_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .src(src), .rot_amt(rot_amt),
        .mask_start(mask_start), .mask_stop(mask_stop), .word_mode(word_mode),
        .sext_en(sext_en), .rsp_valid(rsp_valid), .rsp_rotated(rsp_rotated),
        .rsp_mask(rsp_mask), .rsp_result(rsp_result)
    );

    function automatic logic [63:0] ref_mask(input int b, input int e);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) begin
            if ((b <= e && i >= b && i <= e) || (b > e && (i >= b || i <= e)))
                m[63-i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] ref_rot(input logic [63:0] s, input int n,
                                            input logic wm, input logic se);
        logic [63:0] v = s;
        logic [63:0] r;
        int k;
        if (se) v[63:32] = {32{s[31]}};
        if (wm) begin
            v = {v[31:0], v[31:0]};
            k = n % 32;
        end else begin
            k = n % 64;
        end
        r = v;
        for (int i = 0; i < k; i++) r = {r[62:0], r[63]};
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // apply one request, sample mid-cycle after the capturing edge
    task automatic run(input logic [63:0] s, input int n, input int b, input int e,
                       input logic wm, input logic se);
        @(negedge clk);
        req_valid = 1'b1; src = s; rot_amt = n[5:0];
        mask_start = b[5:0]; mask_stop = e[5:0]; word_mode = wm; sext_en = se;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic full(input string tag, input logic [63:0] s, input int n,
                        input int b, input int e, input logic wm, input logic se);
        logic [63:0] er, em;
        run(s, n, b, e, wm, se);
        er = ref_rot(s, n, wm, se);
        em = ref_mask(b, e);
        check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
        check({tag, " rot"}, rsp_rotated, er);
        check({tag, " mask"}, rsp_mask, em);
        check({tag, " result R7"}, rsp_result, er & em);
    endtask

    initial begin
        fork
            begin
                #(CLK_PERIOD * 150000);
                fails++;
                $display("FAIL watchdog expired");
            end
            begin
                rst = 1'b1; req_valid = 1'b0; src = '0; rot_amt = '0;
                mask_start = '0; mask_stop = '0; word_mode = 1'b0; sext_en = 1'b0;
                repeat (3) @(negedge clk);
                check("R9 reset valid", {63'd0, rsp_valid}, 64'd0);
                rst = 1'b0;

                // R1 worked examples
                run('1, 0, 37, 63, 0, 0);
                check("R1 mask 37..63", rsp_mask, 64'h0000000007ffffff);
                run('1, 0, 0, 37, 0, 0);
                check("R1 mask 0..37", rsp_mask, 64'hfffffffffc000000);
                full("R1 full range", '1, 0, 0, 63, 0, 0);
                // R2 single bit
                run('1, 0, 32, 32, 0, 0);
                check("R2 idx32", rsp_mask, 64'h0000000080000000);
                full("R2 idx0", '1, 0, 0, 0, 0, 0);
                full("R2 idx63", '1, 0, 63, 63, 0, 0);
                // R3 wrap
                run('1, 0, 47, 37, 0, 0);
                check("R3 wrap 47..37", rsp_mask, 64'hfffffffffc01ffff);
                full("R3 wrap 63..0", '1, 0, 63, 0, 0, 0);
                // R4
                run(64'hdeadbeef12345678, 10, 0, 63, 0, 0);
                check("R4 rot10", rsp_rotated, 64'hb6fbbc48d159e37a);
                // R5 and ignored bit 5
                run(64'h00000000deadbeef, 10, 32, 63, 1, 0);
                check("R5 word rot10", rsp_rotated, 64'hb6fbbf7ab6fbbf7a);
                run(64'h12345678deadbeef, 42, 32, 63, 1, 0);
                check("R5 bit5 ignored", rsp_rotated, 64'hb6fbbf7ab6fbbf7a);
                // R6
                run(64'h0000000080000000, 0, 0, 63, 0, 1);
                check("R6 sext neg", rsp_rotated, 64'hffffffff80000000);
                run(64'haaaaaaaa73123456, 0, 0, 63, 0, 1);
                check("R6 sext pos", rsp_rotated, 64'h0000000073123456);
                // R7 all-ones identity
                run('1, 0, 15, 5, 0, 0);
                check("R7 identity", rsp_result, ref_mask(15, 5));
                // R8 hold when idle
                @(negedge clk);
                check("R8 idle valid", {63'd0, rsp_valid}, 64'd0);
                check("R8 hold result", rsp_result, ref_mask(15, 5));

                void'($urandom(32'h1234));
                for (int t = 0; t < 300; t++) begin
                    logic [63:0] s;
                    int n, b, e;
                    logic wm, se;
                    s = {$urandom(), $urandom()};
                    n = $urandom_range(0, 63);
                    b = $urandom_range(0, 63);
                    e = $urandom_range(0, 63);
                    wm = 1'($urandom_range(0, 1));
                    se = 1'($urandom_range(0, 1));
                    full("R4 R5 R6 random", s, n, b, e, wm, se);
                    if (wm) full("R5 random bit5 flip", s, n ^ 32, b, e, wm, se);
                end
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule